// File: doc/BRIEF.md
# Partial-Flag Offset Loader for a Dual FIFO

This block keeps the four threshold registers behind the partial flags of two FIFOs. Each FIFO has an almost-empty offset (X) and an almost-full offset (Y). From them the block derives one active-low almost-empty flag and one active-low almost-full flag per FIFO. The flags are computed from fill counts that the FIFO control logic supplies. The block sits in the clock domain of the counts it is given. Carrying the flags into other clock domains is left to the FIFO wrapper.

During a master reset the block samples a serial-mode pin and a two-bit preset select. These choose how the offsets are set: a fixed preset written into all four registers, one register per load strobe from a parallel data port, or a bit-serial chain that is shifted in one bit per clock. Two per-FIFO partial resets force that FIFO's flags to the empty state for as long as they are held. They leave the offsets, the chosen method and the load progress as they were, so a FIFO can be flushed without being configured again.

Register order in both programming methods is FIFO1 almost-full, FIFO1 almost-empty, FIFO2 almost-full, FIFO2 almost-empty. With the defaults (1024-deep FIFOs, 10-bit offsets) the serial chain is 40 bits long.

Top module: `pfl_offset_loader`

## Requirements
- R1: While mrst_ni is LOW on a rising clock, the method is captured. ser_mode_ni LOW selects serial loading. ser_mode_ni HIGH with preset_sel_i = 00 selects parallel loading. ser_mode_ni HIGH with any other preset_sel_i selects a preset.
- R2: With a preset method, each master-reset clock writes the same value into all four offsets: 8 for preset_sel_i = 01, 16 for 10, and 64 for 11.
- R3: In serial mode, each rising clock with ser_en_ni LOW shifts ser_data_i into the chain. The chain takes the most significant bit first, in the order Y1[9..0], X1[9..0], Y2[9..0], X2[9..0]. Clocks with ser_en_ni HIGH shift nothing.
- R4: A serial load stops after 40 accepted bits. Any further serial bits leave all offsets unchanged.
- R5: In parallel mode, each rising clock with par_load_i HIGH writes par_data_i into the next register, in the order Y1, X1, Y2, X2. Once four strobes have been accepted, further strobes are ignored.
- R6: Inputs that belong to the method not selected (serial bits in parallel or preset mode, load strobes in serial or preset mode) leave all offsets unchanged.
- R7: almost_empty_no[f] is LOW exactly when fill_cnt_i[f] <= X of FIFO f. The flag reflects the count and offset present before a rising clock, and shows them after that edge.
- R8: almost_full_no[f] is LOW exactly when DEPTH - fill_cnt_i[f] <= Y of FIFO f. It has the same one-edge latency as R7.
- R9: While prst_ni[f] is LOW, FIFO f shows almost_empty_no LOW and almost_full_no HIGH. The other FIFO is unaffected. Offsets, method and load progress are retained.
- R10: On rst_ni, and after each master-reset clock, every FIFO shows almost_empty_no LOW and almost_full_no HIGH. rst_ni clears all offsets and selects a preset method of value 0. A master reset into serial or parallel mode clears all offsets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the counts and the programming inputs |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mrst_ni | input | 1 | Synchronous active-low master reset; method is captured while LOW |
| prst_ni | input | NUM_FIFO | Per-FIFO synchronous active-low partial reset |
| ser_mode_ni | input | 1 | LOW selects serial loading at master reset |
| preset_sel_i | input | 2 | Preset choice at master reset (00 = programmed) |
| ser_en_ni | input | 1 | Active-low serial shift enable |
| ser_data_i | input | 1 | Serial offset bit |
| par_load_i | input | 1 | Parallel load strobe |
| par_data_i | input | OFF_W | Low bits of the data port used as the offset value |
| fill_cnt_i | input | NUM_FIFO x CNT_W | Stored word count of each FIFO |
| almost_empty_no | output | NUM_FIFO | Active-low almost-empty flags |
| almost_full_no | output | NUM_FIFO | Active-low almost-full flags |

## Verification
A programming input takes effect in the offset registers at the rising edge that samples it. Because the flag registers sample the offsets of the previous cycle, a flag shows the change at the second edge. A change in fill count shows in the flags at the first edge. The bench drives every input on the falling edge and advances its reference model on the rising edge, using the same pre-edge inputs, so the expected flags line up with that one- and two-edge latency; model and outputs are compared at each falling edge. The offsets are probed through the ports, by setting a count on either side of each threshold and reading the flag one edge later.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

  typedef enum logic [1:0] {
    M_SERIAL   = 2'd0,
    M_PARALLEL = 2'd1,
    M_PRESET   = 2'd2
  } load_method_e;

  function automatic int unsigned preset_offset(input logic [1:0] sel);
    case (sel)
      2'b01:   return 8;
      2'b10:   return 16;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pfl_cfg_ctrl.sv
module pfl_cfg_ctrl
  import pfl_pkg::*;
#(
  parameter int NUM_OFF = 4,
  parameter int OFF_W   = 10,
  localparam int SER_LEN = NUM_OFF * OFF_W,
  localparam int LDC_W   = $clog2(SER_LEN + 1),
  localparam int IDX_W   = $clog2(NUM_OFF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mrst_ni,
  input  logic             ser_mode_ni,
  input  logic [1:0]       preset_sel_i,
  input  logic             ser_en_ni,
  input  logic             par_load_i,
  output logic             cfg_ld_o,
  output logic [OFF_W-1:0] cfg_val_o,
  output logic             shift_en_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             done_o
);

  load_method_e method_q;
  logic [LDC_W-1:0] ld_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      method_q <= M_PRESET;
      ld_cnt_q <= '0;
    end else if (!mrst_ni) begin
      ld_cnt_q <= '0;
      if (!ser_mode_ni)              method_q <= M_SERIAL;
      else if (preset_sel_i == 2'b00) method_q <= M_PARALLEL;
      else                           method_q <= M_PRESET;
    end else if (shift_en_o || wr_en_o) begin
      ld_cnt_q <= ld_cnt_q + 1'b1;
    end
  end

  // preset value only when a preset is chosen; programmed modes start at 0
  assign cfg_ld_o  = !mrst_ni;
  assign cfg_val_o = (ser_mode_ni && preset_sel_i != 2'b00)
                   ? OFF_W'(preset_offset(preset_sel_i)) : '0;

  assign shift_en_o = mrst_ni && (method_q == M_SERIAL) && !ser_en_ni
                   && (ld_cnt_q < LDC_W'(SER_LEN));
  assign wr_en_o    = mrst_ni && (method_q == M_PARALLEL) && par_load_i
                   && (ld_cnt_q < LDC_W'(NUM_OFF));
  assign wr_idx_o   = ld_cnt_q[IDX_W-1:0];

  always_comb begin
    case (method_q)
      M_SERIAL:   done_o = (ld_cnt_q == LDC_W'(SER_LEN));
      M_PARALLEL: done_o = (ld_cnt_q == LDC_W'(NUM_OFF));
      default:    done_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/pfl_offset_bank.sv
module pfl_offset_bank #(
  parameter int NUM_OFF = 4,
  parameter int OFF_W   = 10,
  localparam int IDX_W  = $clog2(NUM_OFF)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_ld_i,
  input  logic [OFF_W-1:0]              cfg_val_i,
  input  logic                          shift_en_i,
  input  logic                          ser_data_i,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [OFF_W-1:0]              wr_data_i,
  output logic [NUM_OFF-1:0][OFF_W-1:0] offs_o
);

  logic [NUM_OFF-1:0] chain_in;

  for (genvar g = 0; g < NUM_OFF; g++) begin : g_off
    // register 0 is at the head of the chain, so it holds the first bits shifted
    if (g == NUM_OFF - 1) begin : g_tail
      assign chain_in[g] = ser_data_i;
    end else begin : g_link
      assign chain_in[g] = offs_o[g+1][OFF_W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   offs_o[g] <= '0;
      else if (cfg_ld_i)                             offs_o[g] <= cfg_val_i;
      else if (shift_en_i)                           offs_o[g] <= {offs_o[g][OFF_W-2:0], chain_in[g]};
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     offs_o[g] <= wr_data_i;
    end
  end

endmodule

// File: rtl/pfl_flag_cmp.sv
module pfl_flag_cmp #(
  parameter int DEPTH = 1024,
  parameter int OFF_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [OFF_W-1:0] x_i,
  input  logic [OFF_W-1:0] y_i,
  output logic             ae_no,
  output logic             af_no
);

  logic [CNT_W-1:0] free_cnt;
  assign free_cnt = CNT_W'(DEPTH) - cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_no <= 1'b0;
      af_no <= 1'b1;
    end else if (hold_i) begin
      ae_no <= 1'b0;
      af_no <= 1'b1;
    end else begin
      ae_no <= cnt_i    > CNT_W'(x_i);
      af_no <= free_cnt > CNT_W'(y_i);
    end
  end

endmodule

// File: rtl/pfl_offset_loader.sv
module pfl_offset_loader #(
  parameter int DEPTH    = 1024,
  parameter int NUM_FIFO = 2,
  localparam int OFF_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           mrst_ni,
  input  logic [NUM_FIFO-1:0]            prst_ni,
  input  logic                           ser_mode_ni,
  input  logic [1:0]                     preset_sel_i,
  input  logic                           ser_en_ni,
  input  logic                           ser_data_i,
  input  logic                           par_load_i,
  input  logic [OFF_W-1:0]               par_data_i,
  input  logic [NUM_FIFO-1:0][CNT_W-1:0] fill_cnt_i,
  output logic [NUM_FIFO-1:0]            almost_empty_no,
  output logic [NUM_FIFO-1:0]            almost_full_no
);

  localparam int NUM_OFF = 2 * NUM_FIFO;
  localparam int IDX_W   = $clog2(NUM_OFF);

  logic                          cfg_ld;
  logic [OFF_W-1:0]              cfg_val;
  logic                          shift_en;
  logic                          wr_en;
  logic [IDX_W-1:0]              wr_idx;
  logic                          done;
  logic [NUM_OFF-1:0][OFF_W-1:0] offs;

  pfl_cfg_ctrl #(.NUM_OFF(NUM_OFF), .OFF_W(OFF_W)) u_ctrl (
    .clk_i, .rst_ni, .mrst_ni, .ser_mode_ni, .preset_sel_i, .ser_en_ni, .par_load_i,
    .cfg_ld_o(cfg_ld), .cfg_val_o(cfg_val), .shift_en_o(shift_en),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .done_o(done)
  );

  pfl_offset_bank #(.NUM_OFF(NUM_OFF), .OFF_W(OFF_W)) u_bank (
    .clk_i, .rst_ni, .cfg_ld_i(cfg_ld), .cfg_val_i(cfg_val),
    .shift_en_i(shift_en), .ser_data_i, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(par_data_i), .offs_o(offs)
  );

  // offset pair per FIFO: even index = almost-full (Y), odd index = almost-empty (X)
  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_fifo
    pfl_flag_cmp #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u_cmp (
      .clk_i, .rst_ni,
      .hold_i(!mrst_ni || !prst_ni[f]),
      .cnt_i (fill_cnt_i[f]),
      .x_i   (offs[2*f+1]),
      .y_i   (offs[2*f]),
      .ae_no (almost_empty_no[f]),
      .af_no (almost_full_no[f])
    );
  end

endmodule

// File: rtl/pfl_checker.sv
module pfl_checker #(
  parameter int DEPTH    = 1024,
  parameter int NUM_FIFO = 2,
  localparam int OFF_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int NUM_OFF = 2 * NUM_FIFO
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           mrst_ni,
  input logic [NUM_FIFO-1:0]            prst_ni,
  input logic [NUM_FIFO-1:0][CNT_W-1:0] fill_cnt_i,
  input logic [NUM_FIFO-1:0]            almost_empty_no,
  input logic [NUM_FIFO-1:0]            almost_full_no,
  input logic [NUM_OFF-1:0][OFF_W-1:0]  offs,
  input logic                           shift_en,
  input logic                           wr_en,
  input logic                           done
);

  a_r10_mrst_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_ni |=> (almost_empty_no == '0) && (almost_full_no == '1));

  // R4 / R5: a completed load freezes the offsets
  a_r4_done_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_ni && done) |=> $stable(offs));

  // R9 / R6: offsets move only on a master reset or an accepted load
  a_r9_offs_retained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrst_ni && !shift_en && !wr_en) |=> $stable(offs));

  for (genvar f = 0; f < NUM_FIFO; f++) begin : g_chk
    a_r9_prst_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prst_ni[f] |=> (!almost_empty_no[f] && almost_full_no[f]));

    a_r7_ae_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mrst_ni && prst_ni[f] && fill_cnt_i[f] <= CNT_W'(offs[2*f+1]))
      |=> !almost_empty_no[f]);

    a_r8_af_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mrst_ni && prst_ni[f] && (CNT_W'(DEPTH) - fill_cnt_i[f]) <= CNT_W'(offs[2*f]))
      |=> !almost_full_no[f]);
  end

endmodule

bind pfl_offset_loader pfl_checker #(.DEPTH(DEPTH), .NUM_FIFO(NUM_FIFO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mrst_ni(mrst_ni), .prst_ni(prst_ni),
  .fill_cnt_i(fill_cnt_i), .almost_empty_no(almost_empty_no),
  .almost_full_no(almost_full_no), .offs(offs), .shift_en(shift_en),
  .wr_en(wr_en), .done(done)
);

// File: tb/pfl_offset_loader_tb.sv
module pfl_offset_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int NF    = 2;
  localparam int OW    = 10;
  localparam int CW    = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mrst_ni = 1'b1;
  logic [NF-1:0] prst_ni = '1;
  logic ser_mode_ni = 1'b1;
  logic [1:0] preset_sel = 2'b00;
  logic ser_en_ni = 1'b1;
  logic ser_data = 1'b0;
  logic par_load = 1'b0;
  logic [OW-1:0] par_data = '0;
  logic [NF-1:0][CW-1:0] fill_cnt = '0;
  logic [NF-1:0] ae_no, af_no;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfl_offset_loader #(.DEPTH(DEPTH), .NUM_FIFO(NF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mrst_ni(mrst_ni), .prst_ni(prst_ni),
    .ser_mode_ni(ser_mode_ni), .preset_sel_i(preset_sel), .ser_en_ni(ser_en_ni),
    .ser_data_i(ser_data), .par_load_i(par_load), .par_data_i(par_data),
    .fill_cnt_i(fill_cnt), .almost_empty_no(ae_no), .almost_full_no(af_no)
  );

  int errors = 0;
  int checks = 0;
  bit run = 0;
  bit finished = 0;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // reference model: 0 serial, 1 parallel, 2 preset
  int m_method = 2;
  int m_off[4];
  int m_idx = 0;
  bit m_ae[NF];
  bit m_af[NF];

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_method = 2; m_idx = 0;
      foreach (m_off[k]) m_off[k] = 0;
      for (int f = 0; f < NF; f++) begin m_ae[f] = 0; m_af[f] = 1; end
    end else begin
      for (int f = 0; f < NF; f++) begin
        if (!mrst_ni || !prst_ni[f]) begin m_ae[f] = 0; m_af[f] = 1; end
        else begin
          m_ae[f] = int'(fill_cnt[f]) > m_off[2*f+1];
          m_af[f] = (DEPTH - int'(fill_cnt[f])) > m_off[2*f];
        end
      end
      if (!mrst_ni) begin
        int v;
        m_idx = 0;
        if (!ser_mode_ni) m_method = 0;
        else if (preset_sel == 2'b00) m_method = 1;
        else m_method = 2;
        v = (m_method != 2) ? 0 : (preset_sel == 2'b01) ? 8 : (preset_sel == 2'b10) ? 16 : 64;
        foreach (m_off[k]) m_off[k] = v;
      end else if (m_method == 0 && !ser_en_ni && m_idx < 4*OW) begin
        if (ser_data) m_off[m_idx/OW] |= 1 << (OW - 1 - m_idx % OW);
        m_idx++;
      end else if (m_method == 1 && par_load && m_idx < 4) begin
        m_off[m_idx] = int'(par_data);
        m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (run) begin
      for (int f = 0; f < NF; f++) begin
        chk("R7 ae model", int'(ae_no[f]), int'(m_ae[f]));
        chk("R8 af model", int'(af_no[f]), int'(m_af[f]));
      end
    end
  end

  task automatic mreset(input logic smode_n, input logic [1:0] sel);
    @(negedge clk);
    mrst_ni = 1'b0; ser_mode_ni = smode_n; preset_sel = sel;
    repeat (2) @(negedge clk);
    mrst_ni = 1'b1;
  endtask

  // set a count, wait one edge, read both flags of that FIFO
  task automatic probe(input string req, input int f, input int c, input bit e_ae, input bit e_af);
    @(negedge clk);
    fill_cnt[f] = CW'(c);
    @(negedge clk);
    chk({req, " almost-empty"}, int'(ae_no[f]), int'(e_ae));
    chk({req, " almost-full"},  int'(af_no[f]), int'(e_af));
    fill_cnt[f] = '0;
  endtask

  task automatic ser_bit(input logic b);
    @(negedge clk);
    ser_en_ni = 1'b0; ser_data = b;
  endtask

  task automatic par_write(input int v);
    @(negedge clk);
    par_load = 1'b1; par_data = OW'(v);
    @(negedge clk);
    par_load = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [4*OW-1:0] word;
    repeat (3) @(negedge clk);
    run = 1;
    chk("R10 reset ae", int'(ae_no), 0);
    chk("R10 reset af", int'(af_no), 3);
    rst_ni = 1'b1;
    // R10: no offsets loaded yet, preset value 0
    probe("R10 after rst", 0, 0, 0, 1);
    probe("R10 after rst", 0, 1, 1, 1);

    // R1 / R2 presets
    mreset(1'b1, 2'b01);
    probe("R2 preset8", 0, 8, 0, 1);
    probe("R2 preset8", 0, 9, 1, 1);
    probe("R2 preset8", 1, 1016, 1, 0);
    probe("R2 preset8", 1, 1015, 1, 1);
    par_write(3);   // R6 strobe ignored in preset mode
    probe("R6 preset ignores strobe", 0, 8, 0, 1);
    mreset(1'b1, 2'b10);
    probe("R2 preset16", 1, 16, 0, 1);
    probe("R2 preset16", 1, 17, 1, 1);
    probe("R2 preset16", 0, 1008, 1, 0);
    probe("R2 preset16", 0, 1007, 1, 1);
    mreset(1'b1, 2'b11);
    probe("R2 preset64", 0, 64, 0, 1);
    probe("R2 preset64", 0, 65, 1, 1);
    probe("R2 preset64", 1, 960, 1, 0);
    probe("R2 preset64", 1, 959, 1, 1);

    // R1 serial; R10 offsets cleared
    mreset(1'b0, 2'b11);
    probe("R10 serial clear", 0, 0, 0, 1);
    probe("R10 serial clear", 0, 1, 1, 1);
    probe("R10 serial clear", 1, 1024, 1, 0);
    probe("R10 serial clear", 1, 1023, 1, 1);
    word = {10'd100, 10'd5, 10'd300, 10'd513};
    for (int i = 4*OW-1; i >= 0; i--) begin
      ser_bit(word[i]);
      if (i == 20) begin
        @(negedge clk); ser_en_ni = 1'b1; ser_data = 1'b1;   // R3 idle cycle
        @(negedge clk); par_load = 1'b1; par_data = '1;      // R6 strobe in serial mode
        @(negedge clk); par_load = 1'b0;
      end
    end
    for (int i = 0; i < 3; i++) ser_bit(1'b1);             // R4 extra bits
    @(negedge clk); ser_en_ni = 1'b1;
    probe("R3 serial X1", 0, 5, 0, 1);
    probe("R3 serial X1", 0, 6, 1, 1);
    probe("R4 serial Y1", 0, 924, 1, 0);
    probe("R4 serial Y1", 0, 923, 1, 1);
    probe("R3 serial X2", 1, 513, 0, 1);
    probe("R3 serial X2", 1, 514, 1, 1);
    probe("R4 serial Y2", 1, 724, 1, 0);
    probe("R4 serial Y2", 1, 723, 1, 1);

    // R9 partial reset on FIFO1 only
    @(negedge clk);
    fill_cnt[0] = CW'(600); fill_cnt[1] = CW'(514); prst_ni[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 prst ae", int'(ae_no[0]), 0);
    chk("R9 prst af", int'(af_no[0]), 1);
    chk("R9 other fifo", int'(ae_no[1]), 1);
    prst_ni[0] = 1'b1; fill_cnt = '0;
    probe("R9 retained", 0, 5, 0, 1);
    probe("R9 retained", 0, 6, 1, 1);
    probe("R9 retained", 0, 924, 1, 0);

    // R1 / R5 parallel
    mreset(1'b1, 2'b00);
    par_write(20); par_write(1000); par_write(0); par_write(1023);
    par_write(7);                                          // R5 fifth ignored
    for (int i = 0; i < 4; i++) ser_bit(1'b1);             // R6 serial ignored
    @(negedge clk); ser_en_ni = 1'b1;
    probe("R5 parallel X1", 0, 1000, 0, 1);
    probe("R5 parallel X1", 0, 1001, 1, 1);
    probe("R5 parallel Y1", 0, 1004, 1, 0);
    probe("R5 parallel Y1", 0, 1003, 1, 1);
    probe("R5 parallel X2", 1, 1023, 0, 1);
    probe("R6 parallel Y2", 1, 1024, 1, 0);
    probe("R7 fifo2 zero", 1, 0, 0, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule